// File: doc/BRIEF.md
# Serial Interrupt Device Agent

This block is the device side of a one-wire serial interrupt bus. The wire is open and shared with a host. The agent watches a vector of local interrupt/data inputs and reports the ones it owns, each in a fixed frame slot. It drives the wire only through a pair of signals, a drive value (`drv_val`) and a drive enable (`drv_en`). The pad buffer outside the block turns that pair into a real wire. The block also reads back the wire level it samples (`line_in`).

A bus cycle runs in this order:
- a start pulse, held low for several clocks;
- a chain of three-clock data frames;
- a stop pulse, whose low width tells every agent the mode for the next cycle.

In quiet mode the agent may open a cycle itself, but only when the bus is idle and an owned input holds a value the host has not yet been given. In continuous mode only the host opens cycles. The agent still answers in its slots whichever side started the cycle.

The state machine has these states:
- IDLE: bus idle.
- REQ: the agent's own one-clock start drive.
- START: start pulse low, waiting for it to rise.
- LEAD: the clock after the rising edge.
- FRAME: walks the slots. A phase field (SAMPLE, RECOVER, TURN) and a slot index go with it.
- STOPWAIT: waiting for the stop pulse.
- STOPLOW: counting the stop width.
- GAP: one clock after the stop pulse.

The transitions are:
- IDLE→START when the line goes low.
- IDLE→REQ when the mode is quiet and an update is pending.
- REQ→START.
- START→LEAD when the line is high.
- LEAD→FRAME, opening slot 0.
- FRAME TURN→FRAME SAMPLE, moving to the next slot.
- FRAME TURN→STOPWAIT after the last slot.
- STOPWAIT→STOPLOW when the line goes low.
- STOPLOW→GAP when the line is high. The mode is latched on this transition.
- GAP→IDLE.

Top module: `sirq_agent`

## Requirements
- R1: When the agent opens a cycle, it drives low (`drv_en`=1, `drv_val`=0) for exactly one clock. It releases the line (`drv_en`=0) in the next clock and never drives high as part of that start.
- R2: The agent never opens a cycle while the bus is active, from the first low clock of a start pulse through the clock after the stop pulse ends. Outside its own sample and recovery clocks it keeps `drv_en` low.
- R3: Clock 0 is the clock in which the line is first sampled high after the start pulse. The sample clock of slot s (frame s+1, 0-based index of `irq_in`) is clock 3(s+1)−1. Recovery follows on the next clock and turnaround on the one after. This holds whoever started the cycle.
- R4: In the sample clock of slot s, the agent drives low only if bit s of the `OWNED` mask is 1 and the latched slot value is 0. Otherwise it leaves the line released. Unowned slots are never driven.
- R5: In the recovery clock the agent drives high exactly when it drove low in the sample clock just before. In the turnaround clock it always releases the line.
- R6: The value of slot s is taken from `irq_in[s]` as sampled at the end of clock 3(s+1)−2. Later changes do not alter that frame's sample or recovery drive.
- R7: After reset the agent drives nothing and is in continuous mode. In continuous mode it never opens a cycle, whatever its inputs do.
- R8: When a stop pulse rises after exactly 2 low clocks, the next cycle is in quiet mode. Any other width (3 or more, or 1) gives continuous mode. The mode changes at no other time.
- R9: After a stop pulse rises, the agent waits one gap clock. With an update pending in quiet mode, its start drive appears on the third clock after the rising clock.
- R10: An update is pending while any owned input differs from the value last latched for its slot. The latched values are 1 after reset. A change that is latched later in the same cycle raises no extra start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NFRAMES | Local interrupt/data values, bit s for slot s, low means asserted |
| line_in | input | 1 | Sampled level of the shared wire |
| drv_en | output | 1 | Enable for the pad driver; 0 releases the wire |
| drv_val | output | 1 | Level driven while `drv_en` is 1 |

## Verification
The bench targets the slot arithmetic: the frame-6 sample must land on clock 17. A design counting from the falling edge, or skipping the lead clock, would drive one to three clocks off and clash with a neighbour's slot. Input changes are placed on either side of a slot's latch clock and inside its sample clock. A design that resampled inside the frame, or that treated an already-delivered change as pending, would break its recovery drive or open a needless cycle. Stop widths of 2 and 3 are alternated. Unowned and in-progress changes are applied while the bus is active or in continuous mode. A mis-decoded width or a missing activity guard would show up as a stray start pulse, or a missing one, right after the stop gap.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_START,
        ST_LEAD,
        ST_FRAME,
        ST_STOPWAIT,
        ST_STOPLOW,
        ST_GAP
    } sirq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } sirq_phase_e;

endpackage

// File: rtl/sirq_change_tracker.sv
module sirq_change_tracker #(
    parameter int                 NFRAMES = 17,
    parameter logic [NFRAMES-1:0] OWNED   = '1,
    parameter int                 SLOT_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NFRAMES-1:0] irq_in,
    input  logic               latch_en,
    input  logic [SLOT_W-1:0]  latch_slot,
    output logic               pending
);

    // Last value handed to the host for each slot; 1 means "not asserted".
    logic [NFRAMES-1:0] delivered;

    for (genvar g = 0; g < NFRAMES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                delivered[g] <= 1'b1;
            end else if (latch_en && latch_slot == SLOT_W'(g)) begin
                delivered[g] <= irq_in[g];
            end
        end
    end

    assign pending = |((irq_in ^ delivered) & OWNED);

endmodule

// File: rtl/sirq_bus_fsm.sv
module sirq_bus_fsm
    import sirq_pkg::*;
#(
    parameter int NFRAMES = 17,
    parameter int SLOT_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_in,
    input  logic               pending,
    input  logic [NFRAMES-1:0] irq_in,
    output sirq_state_e        st,
    output sirq_phase_e        ph,
    output logic [SLOT_W-1:0]  slot,
    output logic               quiet,
    output logic               held,
    output logic               latch_en,
    output logic [SLOT_W-1:0]  latch_slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NFRAMES - 1);

    sirq_state_e       st_n;
    sirq_phase_e       ph_n;
    logic [SLOT_W-1:0] slot_n;
    logic [1:0]        wcnt, wcnt_n;
    logic              quiet_n;

    always_comb begin
        st_n     = st;
        ph_n     = ph;
        slot_n   = slot;
        wcnt_n   = wcnt;
        quiet_n  = quiet;
        latch_en = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (!line_in)              st_n = ST_START;
                else if (quiet && pending) st_n = ST_REQ;
            end
            ST_REQ:   st_n = ST_START;
            ST_START: if (line_in) st_n = ST_LEAD;
            ST_LEAD: begin
                st_n     = ST_FRAME;
                ph_n     = PH_SAMPLE;
                slot_n   = '0;
                latch_en = 1'b1;
            end
            ST_FRAME: begin
                unique case (ph)
                    PH_SAMPLE:  ph_n = PH_RECOVER;
                    PH_RECOVER: ph_n = PH_TURN;
                    PH_TURN: begin
                        if (slot == LAST_SLOT) begin
                            st_n = ST_STOPWAIT;
                        end else begin
                            slot_n   = slot + 1'b1;
                            ph_n     = PH_SAMPLE;
                            latch_en = 1'b1;
                        end
                    end
                    default: ph_n = PH_SAMPLE;
                endcase
            end
            ST_STOPWAIT: begin
                if (!line_in) begin
                    st_n   = ST_STOPLOW;
                    wcnt_n = 2'd1;
                end
            end
            ST_STOPLOW: begin
                if (line_in) begin
                    quiet_n = (wcnt == 2'd2);
                    st_n    = ST_GAP;
                end else if (wcnt != 2'd3) begin
                    wcnt_n = wcnt + 2'd1;
                end
            end
            ST_GAP:  st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    assign latch_slot = slot_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ph    <= PH_SAMPLE;
            slot  <= '0;
            wcnt  <= '0;
            quiet <= 1'b0;
            held  <= 1'b1;
        end else begin
            st    <= st_n;
            ph    <= ph_n;
            slot  <= slot_n;
            wcnt  <= wcnt_n;
            quiet <= quiet_n;
            if (latch_en) held <= irq_in[slot_n];
        end
    end

endmodule

// File: rtl/sirq_slot_driver.sv
module sirq_slot_driver
    import sirq_pkg::*;
#(
    parameter int                 NFRAMES = 17,
    parameter logic [NFRAMES-1:0] OWNED   = '1,
    parameter int                 SLOT_W  = 5
) (
    input  sirq_state_e       st,
    input  sirq_phase_e       ph,
    input  logic [SLOT_W-1:0] slot,
    input  logic              held,
    output logic              drv_en,
    output logic              drv_val
);

    // Output process
    always_comb begin
        drv_en  = 1'b0;
        drv_val = 1'b0;
        if (st == ST_REQ) begin
            drv_en = 1'b1;
        end else if (st == ST_FRAME && OWNED[slot] && !held) begin
            if (ph == PH_SAMPLE) begin
                drv_en = 1'b1;
            end else if (ph == PH_RECOVER) begin
                drv_en  = 1'b1;
                drv_val = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
    import sirq_pkg::*;
#(
    parameter int                 NFRAMES = 17,
    parameter logic [NFRAMES-1:0] OWNED   = NFRAMES'(17'h01022)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NFRAMES-1:0] irq_in,
    input  logic               line_in,
    output logic               drv_en,
    output logic               drv_val
);

    localparam int SLOT_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1;

    sirq_state_e       st;
    sirq_phase_e       ph;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] latch_slot;
    logic              quiet;
    logic              held;
    logic              latch_en;
    logic              pending;

    sirq_change_tracker #(
        .NFRAMES(NFRAMES),
        .OWNED  (OWNED),
        .SLOT_W (SLOT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .latch_en  (latch_en),
        .latch_slot(latch_slot),
        .pending   (pending)
    );

    sirq_bus_fsm #(
        .NFRAMES(NFRAMES),
        .SLOT_W (SLOT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .pending   (pending),
        .irq_in    (irq_in),
        .st        (st),
        .ph        (ph),
        .slot      (slot),
        .quiet     (quiet),
        .held      (held),
        .latch_en  (latch_en),
        .latch_slot(latch_slot)
    );

    sirq_slot_driver #(
        .NFRAMES(NFRAMES),
        .OWNED  (OWNED),
        .SLOT_W (SLOT_W)
    ) u_drv (
        .st     (st),
        .ph     (ph),
        .slot   (slot),
        .held   (held),
        .drv_en (drv_en),
        .drv_val(drv_val)
    );

endmodule

// File: rtl/sirq_agent_checker.sv
module sirq_agent_checker
    import sirq_pkg::*;
#(
    parameter int                 NFRAMES = 17,
    parameter logic [NFRAMES-1:0] OWNED   = '1,
    parameter int                 SLOT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              drv_en,
    input logic              drv_val,
    input sirq_state_e       st,
    input logic [SLOT_W-1:0] slot,
    input logic              quiet
);

    AST_START_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REQ) |=> !drv_en); // R1

    AST_START_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REQ) |-> ($past(st) == ST_IDLE)); // R2

    AST_LOW_ONLY_OWNED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && !drv_val && st == ST_FRAME) |-> OWNED[slot]); // R4

    AST_HIGH_AFTER_OWN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && drv_val) |-> $past(drv_en && !drv_val)); // R5

    AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && drv_val) |=> !drv_en); // R5

    AST_NO_START_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |-> (st != ST_REQ)); // R7

    AST_MODE_AT_STOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet != $past(quiet)) |-> ($past(st) == ST_STOPLOW)); // R8

endmodule

bind sirq_agent sirq_agent_checker #(
    .NFRAMES(NFRAMES),
    .OWNED  (OWNED),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .drv_en (drv_en),
    .drv_val(drv_val),
    .st     (st),
    .slot   (slot),
    .quiet  (quiet)
);

// File: tb/sirq_agent_test.sv
`timescale 1ns/1ps
module sirq_agent_test;

    localparam int              NF    = 17;
    localparam logic [NF-1:0]   OWN   = 17'h01022;  // slots 1, 5, 12
    localparam int              LASTC = 3*NF + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] irq = '1;
    logic          host_en = 1'b0;
    logic          host_val = 1'b1;
    logic          drv_en, drv_val;
    wire           line = drv_en ? drv_val : (host_en ? host_val : 1'b1);

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  seen_en  [0:LASTC];
    bit  seen_val [0:LASTC];
    int  chg_clk = -1;
    int  chg_slot = 0;
    bit  chg_val = 1'b0;

    always #2.5 clk = ~clk;

    sirq_agent #(.NFRAMES(NF), .OWNED(OWN)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq),
        .line_in(line),
        .drv_en (drv_en),
        .drv_val(drv_val)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 idle, 1 start low, 2 counting clocks, 3 waiting stop,
    //       4 stop low, 5 gap, 6 own start drive
    int    m_mode, m_clk, m_w;
    bit    m_quiet, m_held;
    bit    m_sent [NF];
    bit    exp_en, exp_val;
    string exp_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_clk = 0; m_w = 0; m_quiet = 0; m_held = 1;
            foreach (m_sent[i]) m_sent[i] = 1'b1;
            exp_en = 0; exp_val = 0; exp_tag = "R7";
        end else begin
            bit diff;
            diff = 1'b0;
            foreach (m_sent[i]) if (OWN[i] && irq[i] != m_sent[i]) diff = 1'b1;
            case (m_mode)
                0: if (!line) m_mode = 1; else if (m_quiet && diff) m_mode = 6;
                6: m_mode = 1;
                1: if (line) begin m_mode = 2; m_clk = 1; end
                2: begin
                    m_clk++;
                    if (m_clk > LASTC) m_mode = 3;
                    else if (m_clk >= 2 && (m_clk - 2) % 3 == 0) begin
                        m_held = irq[(m_clk-2)/3];
                        m_sent[(m_clk-2)/3] = irq[(m_clk-2)/3];
                    end
                end
                3: if (!line) begin m_mode = 4; m_w = 1; end
                4: if (line) begin m_quiet = (m_w == 2); m_mode = 5; end
                   else m_w++;
                5: m_mode = 0;
                default: m_mode = 0;
            endcase
            exp_en = 0; exp_val = 0; exp_tag = "R2";
            if (m_mode == 6) begin
                exp_en = 1; exp_tag = "R1";
            end else if (m_mode == 2 && m_clk >= 2) begin
                int s, p;
                s = (m_clk - 2) / 3;
                p = (m_clk - 2) % 3;
                exp_tag = (p == 0) ? "R4" : "R5";
                if (OWN[s] && !m_held && p < 2) begin
                    exp_en = 1; exp_val = (p == 1);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(drv_en == exp_en && (!exp_en || drv_val == exp_val), exp_tag,
                "per-clock drive {en,val}", {drv_en, drv_val & drv_en},
                {exp_en, exp_val & exp_en});
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- host model ----------------
    task automatic host_cycle(input int lowlen, input int stopw, input bit by_agent);
        int nlow;
        nlow = by_agent ? lowlen - 1 : lowlen;
        if (by_agent) begin
            @(negedge clk);
            chk(!drv_en, "R1", "agent released after one start clock", drv_en, 0);
        end
        repeat (nlow) begin host_en = 1; host_val = 0; @(negedge clk); end
        host_en = 1; host_val = 1;
        seen_en[0] = drv_en; seen_val[0] = drv_val;
        @(negedge clk);
        host_en = 0;
        for (int j = 1; j <= LASTC; j++) begin
            seen_en[j] = drv_en; seen_val[j] = drv_val;
            if (chg_clk == j) irq[chg_slot] = chg_val;
            @(negedge clk);
        end
        chg_clk = -1;
        repeat (stopw) begin host_en = 1; host_val = 0; @(negedge clk); end
        host_en = 1; host_val = 1;
        @(negedge clk);
        host_en = 0;
    endtask

    task automatic wait_agent_start(output int off);
        off = -1;
        for (int k = 0; k < 30; k++) begin
            if (drv_en && !drv_val) begin off = k; break; end
            @(negedge clk);
        end
    endtask

    task automatic count_starts(input int n, output int got);
        got = 0;
        for (int k = 0; k < n; k++) begin
            if (drv_en) got++;
            @(negedge clk);
        end
    endtask

    initial begin
        int off, got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(!drv_en, "R7", "released after reset", drv_en, 0);

        // Continuous mode: changes must not start a cycle
        irq[5] = 1'b0; irq[3] = 1'b0;
        count_starts(20, got);
        chk(got == 0, "R7", "no start in continuous mode", got, 0);

        // Host cycle, stop width 3 keeps continuous
        host_cycle(4, 3, 1'b0);
        chk(!seen_en[16], "R3", "clock 16 released", seen_en[16], 0);
        chk(seen_en[17] && !seen_val[17], "R3", "slot 5 low on clock 17",
            {seen_en[17], seen_val[17]}, 2);
        chk(seen_en[18] && seen_val[18], "R5", "slot 5 high on clock 18",
            {seen_en[18], seen_val[18]}, 3);
        chk(!seen_en[19], "R5", "turnaround release clock 19", seen_en[19], 0);
        chk(!seen_en[11], "R4", "unowned slot 3 not driven", seen_en[11], 0);
        chk(!seen_en[5], "R4", "owned slot 1 high not driven", seen_en[5], 0);
        irq[5] = 1'b1;
        count_starts(20, got);
        chk(got == 0, "R8", "width 3 stays continuous", got, 0);

        // Host cycle delivers slot 5 high; stop width 2 selects quiet
        host_cycle(8, 2, 1'b0);
        count_starts(20, got);
        chk(got == 0, "R10", "nothing pending after delivery", got, 0);

        // Unowned change in quiet mode
        irq[3] = 1'b1;
        count_starts(10, got);
        chk(got == 0, "R4", "unowned change starts nothing", got, 0);

        // Quiet: owned change starts a cycle
        irq[1] = 1'b0;
        wait_agent_start(off);
        chk(off >= 0, "R1", "agent start pulse seen", off, 1);
        chg_clk = 10; chg_slot = 12; chg_val = 1'b0;  // before slot 12 latch
        host_cycle(4, 2, 1'b1);
        chk(seen_en[5] && !seen_val[5], "R3", "slot 1 low on clock 5",
            {seen_en[5], seen_val[5]}, 2);
        chk(seen_en[38] && !seen_val[38], "R10", "slot 12 change delivered in cycle",
            {seen_en[38], seen_val[38]}, 2);
        count_starts(20, got);
        chk(got == 0, "R10", "no extra start for in-cycle change", got, 0);

        // Host-started cycle in quiet mode, late change to slot 5
        chg_clk = 40; chg_slot = 5; chg_val = 1'b0;
        host_cycle(5, 2, 1'b0);
        wait_agent_start(off);
        chk(off == 2, "R9", "start third clock after stop rise", off, 2);

        // Mid-frame change of slot 12 in its sample clock; end in continuous
        chg_clk = 38; chg_slot = 12; chg_val = 1'b1;
        host_cycle(4, 3, 1'b1);
        chk(seen_en[17] && !seen_val[17], "R3", "slot 5 delivered low",
            {seen_en[17], seen_val[17]}, 2);
        chk(seen_en[39] && seen_val[39], "R6", "slot 12 recovery kept after change",
            {seen_en[39], seen_val[39]}, 3);
        count_starts(20, got);
        chk(got == 0, "R8", "width 3 returns to continuous", got, 0);

        host_cycle(4, 2, 1'b0);
        chk(!seen_en[38], "R4", "slot 12 now high, released", seen_en[38], 0);
        repeat (5) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule